// File: doc/BRIEF.md
# Inter-processor signal controller

This block lets one processor raise numbered signals toward other clients and take the signals aimed at itself. Software drives it through a 32-bit register bus. Every signal is named by one packed ID word: the client number sits in bits 31:16 and the signal number in bits 15:0. Software writes an ID to the send register, and the block emits it on an outgoing strobe port. The interconnect delivers signals for this processor on an incoming strobe port in the same form.

On the receive side the block keeps a pending bit and an enable bit for each supported (client, signal) pair. A fixed table, computed from parameters, maps each pair to a slot. Software enables, disables and clears a signal by writing its packed ID to separate command registers. A level-high summary interrupt stays asserted while any enabled signal is pending. The interrupt service loop reads the receive register, clears the ID it returned, and stops when the read gives all ones.

Top module: `ipsig_ctrl`

## Requirements
- R1: With default parameters there are 48 slots. Slot k stands for client 1 + k/16 and signal k mod 16, so the ID is {client[15:0], signal[15:0]}. Slot 0 is 0x00010000 and slot 47 is 0x0003000F.
- R2: A bus write of an ID to offset 0x0C drives tx_valid high for exactly one cycle, in the cycle after the write, with tx_id equal to the written word.
- R3: An rx_valid strobe whose rx_id matches a table entry sets that slot's pending bit. A strobe with an ID that matches no entry changes nothing.
- R4: Writing an ID to offset 0x14 enables that slot. Writing an ID to offset 0x18 disables it.
- R5: A read of offset 0x10 returns the ID of the lowest-numbered slot that is both pending and enabled. It returns 0xFFFFFFFF when no such slot exists.
- R6: Writing an ID to offset 0x1C clears that slot's pending bit.
- R7: Writing a client number in bits 15:0 to offset 0x38 clears the pending bits of every slot that belongs to that client and leaves other clients' bits unchanged.
- R8: irq is high exactly when at least one slot is both pending and enabled. A read-then-clear loop therefore drains every pending event, and irq ends low.
- R9: When an incoming strobe and a clear for the same slot (by ID or by client) occur in the same cycle, the slot ends up pending.
- R10: A disabled slot still latches a pending event, but that event raises no interrupt and is not reported. Enabling the slot later exposes the event.
- R11: A command write with an ID that is not in the table has no effect. A read of any offset other than 0x10 returns zero.
- R12: After reset, no slot is pending or enabled, irq and tx_valid are low, and offset 0x10 reads 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while bus_rd is high, zero otherwise |
| tx_valid | output | 1 | Outgoing signal strobe |
| tx_id | output | 32 | Outgoing packed signal ID |
| rx_valid | input | 1 | Incoming signal strobe |
| rx_id | input | 32 | Incoming packed signal ID |
| irq | output | 1 | Level-high summary interrupt |

## Verification
An incoming strobe and a software clear can land on the same slot in the same clock: a clear by ID, or a clear of the whole client. The bench drives rx_valid and the clear write on the same falling edge, so both are sampled by one rising edge. It then reads the receive register and expects the slot to be reported, because the set must win. The same collision is run against a client-wide clear, and a bound property requires every slot that was hit by a strobe to be pending one cycle later, whatever command arrived with it.

// File: rtl/ipsig_pkg.sv
package ipsig_pkg;

  localparam int ID_W   = 32;
  localparam int HALF_W = 16;

  localparam logic [7:0] OFF_SEND = 8'h0C;
  localparam logic [7:0] OFF_RECV = 8'h10;
  localparam logic [7:0] OFF_EN   = 8'h14;
  localparam logic [7:0] OFF_DIS  = 8'h18;
  localparam logic [7:0] OFF_CLR  = 8'h1C;
  localparam logic [7:0] OFF_CCLR = 8'h38;

  localparam logic [ID_W-1:0] NONE_ID = '1;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_SEND,
    CMD_EN,
    CMD_DIS,
    CMD_CLR,
    CMD_CCLR
  } cmd_e;

  // Client number of a table slot.
  function automatic logic [HALF_W-1:0] slot_client(int k, int per_client, int first_client);
    return HALF_W'(first_client + k / per_client);
  endfunction

  // Signal number of a table slot.
  function automatic logic [HALF_W-1:0] slot_signal(int k, int per_client);
    return HALF_W'(k % per_client);
  endfunction

  // Packed ID of a table slot: client high, signal low.
  function automatic logic [ID_W-1:0] slot_id(int k, int per_client, int first_client);
    return {slot_client(k, per_client, first_client), slot_signal(k, per_client)};
  endfunction

  function automatic cmd_e decode_cmd(logic wr, logic [7:0] addr);
    if (!wr) return CMD_NONE;
    case (addr)
      OFF_SEND: return CMD_SEND;
      OFF_EN:   return CMD_EN;
      OFF_DIS:  return CMD_DIS;
      OFF_CLR:  return CMD_CLR;
      OFF_CCLR: return CMD_CCLR;
      default:  return CMD_NONE;
    endcase
  endfunction

endpackage

// File: rtl/ipsig_decode.sv
// Maps a packed ID onto the slot table: exact-match one-hot vector.
module ipsig_decode
  import ipsig_pkg::*;
#(
  parameter int NUM_SLOTS    = 48,
  parameter int PER_CLIENT   = 16,
  parameter int FIRST_CLIENT = 1
) (
  input  logic [ID_W-1:0]      id,
  output logic [NUM_SLOTS-1:0] hit
);

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    assign hit[k] = (id == slot_id(k, PER_CLIENT, FIRST_CLIENT));
  end

endmodule

// File: rtl/ipsig_state.sv
// Pending and enable bits per slot. Set beats clear.
module ipsig_state #(
  parameter int NUM_SLOTS = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] set_vec,
  input  logic [NUM_SLOTS-1:0] clr_vec,
  input  logic [NUM_SLOTS-1:0] en_vec,
  input  logic [NUM_SLOTS-1:0] dis_vec,
  output logic [NUM_SLOTS-1:0] pending_q,
  output logic [NUM_SLOTS-1:0] enable_q
);

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pending_q[k] <= 1'b0;
        enable_q[k]  <= 1'b0;
      end else begin
        if (set_vec[k])      pending_q[k] <= 1'b1;
        else if (clr_vec[k]) pending_q[k] <= 1'b0;
        if (en_vec[k])       enable_q[k]  <= 1'b1;
        else if (dis_vec[k]) enable_q[k]  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ipsig_pick.sv
// Lowest active slot wins; reports its packed ID or all ones.
module ipsig_pick
  import ipsig_pkg::*;
#(
  parameter int NUM_SLOTS    = 48,
  parameter int PER_CLIENT   = 16,
  parameter int FIRST_CLIENT = 1
) (
  input  logic [NUM_SLOTS-1:0] active,
  output logic [ID_W-1:0]      recv_word
);

  always_comb begin
    recv_word = NONE_ID;
    for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
      if (active[k]) recv_word = slot_id(k, PER_CLIENT, FIRST_CLIENT);
    end
  end

endmodule

// File: rtl/ipsig_ctrl.sv
module ipsig_ctrl
  import ipsig_pkg::*;
#(
  parameter int NUM_SLOTS    = 48,
  parameter int PER_CLIENT   = 16,
  parameter int FIRST_CLIENT = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tx_valid,
  output logic [31:0] tx_id,
  input  logic        rx_valid,
  input  logic [31:0] rx_id,
  output logic        irq
);

  // Named internal events, visible to the bound checker.
  cmd_e                 cmd;
  logic [NUM_SLOTS-1:0] rx_hit;
  logic [NUM_SLOTS-1:0] cmd_hit;
  logic [NUM_SLOTS-1:0] client_hit;
  logic [NUM_SLOTS-1:0] pending_q;
  logic [NUM_SLOTS-1:0] enable_q;
  logic [NUM_SLOTS-1:0] active;
  logic [NUM_SLOTS-1:0] set_vec, clr_vec, en_vec, dis_vec;
  logic [ID_W-1:0]      recv_word;

  assign cmd = decode_cmd(bus_wr, bus_addr);

  ipsig_decode #(.NUM_SLOTS(NUM_SLOTS), .PER_CLIENT(PER_CLIENT), .FIRST_CLIENT(FIRST_CLIENT))
    u_rx_dec (.id(rx_id), .hit(rx_hit));

  ipsig_decode #(.NUM_SLOTS(NUM_SLOTS), .PER_CLIENT(PER_CLIENT), .FIRST_CLIENT(FIRST_CLIENT))
    u_cmd_dec (.id(bus_wdata), .hit(cmd_hit));

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_client
    assign client_hit[k] = (bus_wdata[HALF_W-1:0] == slot_client(k, PER_CLIENT, FIRST_CLIENT));
  end

  always_comb begin
    set_vec = rx_valid ? rx_hit : '0;
    clr_vec = '0;
    en_vec  = '0;
    dis_vec = '0;
    case (cmd)
      CMD_CLR:  clr_vec = cmd_hit;
      CMD_CCLR: clr_vec = client_hit;
      CMD_EN:   en_vec  = cmd_hit;
      CMD_DIS:  dis_vec = cmd_hit;
      default:  ;
    endcase
  end

  ipsig_state #(.NUM_SLOTS(NUM_SLOTS)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .en_vec   (en_vec),
    .dis_vec  (dis_vec),
    .pending_q(pending_q),
    .enable_q (enable_q)
  );

  assign active = pending_q & enable_q;

  ipsig_pick #(.NUM_SLOTS(NUM_SLOTS), .PER_CLIENT(PER_CLIENT), .FIRST_CLIENT(FIRST_CLIENT))
    u_pick (.active(active), .recv_word(recv_word));

  assign irq = |active;

  // Outgoing strobe: one registered pulse per send write.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_id    <= '0;
    end else begin
      tx_valid <= (cmd == CMD_SEND);
      if (cmd == CMD_SEND) tx_id <= bus_wdata;
    end
  end

  assign bus_rdata = (bus_rd && bus_addr == OFF_RECV) ? recv_word : '0;

endmodule

// File: rtl/ipsig_ctrl_chk.sv
module ipsig_ctrl_chk
  import ipsig_pkg::*;
#(
  parameter int NUM_SLOTS = 48
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic [7:0]           bus_addr,
  input logic [31:0]          bus_wdata,
  input logic                 tx_valid,
  input logic [31:0]          tx_id,
  input logic                 rx_valid,
  input logic                 irq,
  input logic [NUM_SLOTS-1:0] rx_hit,
  input logic [NUM_SLOTS-1:0] cmd_hit,
  input logic [NUM_SLOTS-1:0] pending_q,
  input logic [NUM_SLOTS-1:0] enable_q,
  input logic [ID_W-1:0]      recv_word
);

  a_r2_send_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_SEND) |=> (tx_valid && tx_id == $past(bus_wdata)));

  a_r2_send_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == OFF_SEND) |=> !tx_valid);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> ((pending_q & $past(rx_hit)) == $past(rx_hit)));

  a_r6_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_CLR && !rx_valid) |=> ((pending_q & $past(cmd_hit)) == '0));

  a_r4_enable_done: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_EN) |=> ((enable_q & $past(cmd_hit)) == $past(cmd_hit)));

  a_r8_irq_vs_recv: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (recv_word != NONE_ID));

  a_r3_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_hit));

endmodule

bind ipsig_ctrl ipsig_ctrl_chk #(.NUM_SLOTS(NUM_SLOTS)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .tx_valid (tx_valid),
  .tx_id    (tx_id),
  .rx_valid (rx_valid),
  .irq      (irq),
  .rx_hit   (rx_hit),
  .cmd_hit  (cmd_hit),
  .pending_q(pending_q),
  .enable_q (enable_q),
  .recv_word(recv_word)
);

// File: tb/ipsig_ctrl_tb_top.sv
`timescale 1ns/100ps
module ipsig_ctrl_tb_top;

  localparam logic [7:0] A_SEND = 8'h0C, A_RECV = 8'h10, A_EN = 8'h14,
                         A_DIS = 8'h18, A_CLR = 8'h1C, A_CCLR = 8'h38;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid;
  logic [31:0] tx_id;
  logic        rx_valid = 1'b0;
  logic [31:0] rx_id = '0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ipsig_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_id(tx_id), .rx_valid(rx_valid),
    .rx_id(rx_id), .irq(irq)
  );

  // Bench-side view of the slot table (R1): 16 signals per client, clients from 1.
  function automatic logic [31:0] sid(int k);
    logic [15:0] c, s;
    c = 16'(k / 16 + 1);
    s = 16'(k - (k / 16) * 16);
    return (32'(c) << 16) | 32'(s);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic rx(logic [31:0] id);
    @(negedge clk);
    rx_valid = 1'b1; rx_id = id;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic rx_with_wr(logic [31:0] id, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_id = id;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    rx_valid = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic expect_recv(string req, logic [31:0] exp);
    logic [31:0] v;
    rd(A_RECV, v);
    check(req, v, exp);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R12 irq after reset", 32'(irq), 32'd0);
    check("R12 tx_valid after reset", 32'(tx_valid), 32'd0);
    expect_recv("R12 recv after reset", ONES);
    rd(A_EN, v);
    check("R11 write-only register reads zero", v, 32'd0);
  endtask

  task automatic t_send;
    wr(A_SEND, 32'h0002_0007);
    check("R2 tx_valid pulse", 32'(tx_valid), 32'd1);
    check("R2 tx_id value", tx_id, 32'h0002_0007);
    @(negedge clk);
    check("R2 tx_valid one cycle", 32'(tx_valid), 32'd0);
    check("R2 send sets no local pending", 32'(irq), 32'd0);
  endtask

  task automatic t_disabled_latch;
    rx(sid(5));
    check("R10 disabled pending gives no irq", 32'(irq), 32'd0);
    expect_recv("R10 disabled pending not reported", ONES);
    wr(A_EN, sid(5));
    check("R3 R10 enable exposes latched event irq", 32'(irq), 32'd1);
    expect_recv("R3 R10 enable exposes latched event", sid(5));
  endtask

  task automatic t_priority;
    wr(A_EN, sid(17));
    wr(A_EN, sid(47));
    rx(sid(47));
    rx(sid(17));
    expect_recv("R5 lowest slot first", sid(5));
    wr(A_CLR, sid(5));
    expect_recv("R6 R5 next after clear", sid(17));
    wr(A_CLR, sid(17));
    expect_recv("R1 last slot id", 32'h0003_000F);
    wr(A_CLR, sid(47));
    expect_recv("R6 all cleared", ONES);
    check("R8 irq low when drained", 32'(irq), 32'd0);
  endtask

  task automatic t_disable;
    rx(sid(17));
    expect_recv("R4 enabled slot reported", sid(17));
    wr(A_DIS, sid(17));
    check("R4 disable drops irq", 32'(irq), 32'd0);
    expect_recv("R4 disabled slot hidden", ONES);
    wr(A_EN, sid(17));
    expect_recv("R10 pending kept while disabled", sid(17));
    wr(A_CLR, sid(17));
  endtask

  task automatic t_unknown;
    logic [31:0] v;
    rx(32'h0009_0001);
    check("R3 unknown strobe ignored irq", 32'(irq), 32'd0);
    wr(A_EN, 32'h0001_0010);
    rx(32'h0001_0010);
    check("R11 unknown enable has no effect", 32'(irq), 32'd0);
    expect_recv("R11 unknown id never reported", ONES);
    rd(8'h24, v);
    check("R11 unmapped offset reads zero", v, 32'd0);
    rx(sid(5));
    wr(A_CLR, 32'h0001_0010);
    expect_recv("R11 unknown clear has no effect", sid(5));
    wr(A_CLR, sid(5));
  endtask

  task automatic t_client_clear;
    wr(A_EN, sid(0));
    wr(A_EN, sid(20));
    rx(sid(0)); rx(sid(20)); rx(sid(47));
    expect_recv("R1 first slot id", 32'h0001_0000);
    wr(A_CCLR, 32'd1);
    expect_recv("R7 client 1 cleared only", sid(20));
    wr(A_CCLR, 32'd2);
    expect_recv("R7 client 2 cleared only", sid(47));
    wr(A_CCLR, 32'd3);
    expect_recv("R7 client 3 cleared", ONES);
  endtask

  task automatic t_collision;
    rx_with_wr(sid(20), A_CLR, sid(20));
    expect_recv("R9 set beats clear by id", sid(20));
    wr(A_CLR, sid(20));
    rx_with_wr(sid(47), A_CCLR, 32'd3);
    expect_recv("R9 set beats client clear", sid(47));
    wr(A_CLR, sid(47));
    expect_recv("R9 cleanup", ONES);
  endtask

  task automatic t_loop;
    logic [31:0] v;
    int n;
    rx(sid(0)); rx(sid(5)); rx(sid(17));
    n = 0;
    for (int i = 0; i < 10; i++) begin
      rd(A_RECV, v);
      if (v == ONES) break;
      n++;
      wr(A_CLR, v);
    end
    check("R8 loop drained count", 32'(n), 32'd3);
    check("R8 irq low after loop", 32'(irq), 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_send();
    t_disabled_latch();
    t_priority();
    t_disable();
    t_unknown();
    t_client_clear();
    t_collision();
    t_loop();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule